// File: doc/BRIEF.md
# Global 64-bit Counter with Compare Channel

This block is a free-running 64-bit up-counter with a single 64-bit compare channel, reached over a plain 32-bit register bus (address, write enable, write data, registered read data). Software starts or stops the counter with a control bit and can load either 32-bit half at any time. Reads return the live count half by half with no snapshot, so software builds a consistent 64-bit value by reading the high half, then the low half, then the high half again, and retrying if the two high readings differ.

The compare channel flags a match when the enabled comparator sees the counter equal to the full 64-bit compare value. A sticky status bit records the match and, gated by an enable bit, drives the interrupt line. In auto-increment mode each match adds a programmed increment to the compare value, which yields a periodic interrupt. Every write to a counter half, a compare half, the increment or the control register sets a sticky acknowledge bit, which software polls and then clears by writing 1 to it.

Top module: `gcount_cmp_timer`

## Requirements
- R1: After reset every register reads zero, the counter is stopped and `irq` is low.
- R2: While control bit 8 (offset 0x240) is 1 the counter adds one on each clock, with carry from the low half into the high half; while it is 0 the counter holds its value.
- R3: The counter low half sits at offset 0x100 and the high half at 0x104; each can be written on its own, and reads return the live value with no latching, so two low-half reads on consecutive cycles of a running counter differ by exactly 1.
- R4: Writing the counter low or high half sets bit 0 or bit 1 respectively of the counter acknowledge register at 0x110; writing a 1 to one of those bits clears it and leaves the other bit alone.
- R5: The compare value low half (0x200), high half (0x204) and the increment (0x208) read back what was last written.
- R6: With control bit 0 set, a counter value equal to the 64-bit compare value sets status bit 0 (offset 0x244) on the next clock; with control bit 0 clear no match is ever flagged.
- R7: With control bit 1 set, every match adds the increment to the compare value, so matches repeat every increment-many counts.
- R8: `irq` is high exactly when status bit 0 and enable bit 0 (offset 0x248) are both 1.
- R9: Writing 1 to status bit 0 clears it, writing 0 leaves it unchanged, and a match in the same cycle as a clearing write keeps the bit set.
- R10: Writes to compare low, compare high, increment and control set bits 0, 1, 2 and 16 of the acknowledge register at 0x24C; each bit clears only when 1 is written to it, so writing 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (12) | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, registered one cycle after the address |
| irq | output | 1 | Compare interrupt, status AND enable |

## Verification
The interesting collision is a match that lands in the same cycle as software's clearing write to the status bit. The bench provokes it by stopping the counter on a value equal to the compare value with the comparator enabled, so a match is flagged on every cycle, and then writing 1 to the status bit. The status must still read 1 afterwards, and it must drop only once the comparator is disabled and the clear is repeated. A second overlap, an auto-increment update of the compare value racing a running count, is judged by running an exact number of counts and checking both the final count and the advanced compare value.

// File: rtl/gct_pkg.sv
package gct_pkg;

  // Register byte offsets (16 bits wide; the top slices them to its address width)
  localparam logic [15:0] OFF_CNT_LO  = 16'h0100;
  localparam logic [15:0] OFF_CNT_HI  = 16'h0104;
  localparam logic [15:0] OFF_CNT_ACK = 16'h0110;
  localparam logic [15:0] OFF_CMP_LO  = 16'h0200;
  localparam logic [15:0] OFF_CMP_HI  = 16'h0204;
  localparam logic [15:0] OFF_CMP_INC = 16'h0208;
  localparam logic [15:0] OFF_CTRL    = 16'h0240;
  localparam logic [15:0] OFF_IST     = 16'h0244;
  localparam logic [15:0] OFF_IEN     = 16'h0248;
  localparam logic [15:0] OFF_GEN_ACK = 16'h024C;

  // Control register bit positions
  localparam int CTRL_RUN_BIT  = 8;
  localparam int CTRL_AINC_BIT = 1;
  localparam int CTRL_CEN_BIT  = 0;

  // General acknowledge register bit positions
  localparam int GACK_CMP_LO_BIT  = 0;
  localparam int GACK_CMP_HI_BIT  = 1;
  localparam int GACK_INC_BIT     = 2;
  localparam int GACK_CTRL_BIT    = 16;
  localparam int GACK_NUM         = 4;
  localparam int CACK_NUM         = 2;

  // One-hot decoded write strobes
  typedef struct packed {
    logic cnt_lo;
    logic cnt_hi;
    logic cnt_ack;
    logic cmp_lo;
    logic cmp_hi;
    logic cmp_inc;
    logic ctrl;
    logic ist;
    logic ien;
    logic gen_ack;
  } wr_dec_t;

endpackage

// File: rtl/gct_w1c_bits.sv
module gct_w1c_bits #(
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] set_i,
  input  logic          clr_we,
  input  logic [NB-1:0] clr_mask,
  output logic [NB-1:0] bits_o
);

  for (genvar i = 0; i < NB; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        bits_o[i] <= 1'b0;
      else if (set_i[i])
        bits_o[i] <= 1'b1;
      else if (clr_we && clr_mask[i])
        bits_o[i] <= 1'b0;
    end

    // R4 / R10: a set acknowledge bit survives any write that does not clear it
    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
      (bits_o[i] && !(clr_we && clr_mask[i])) |=> bits_o[i]);

    // R10: a fresh write always raises its acknowledge bit
    p_ack_set_r10: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> bits_o[i]);
  end

endmodule

// File: rtl/gct_counter.sv
module gct_counter #(
  parameter int DW = 32,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] cnt
);

  logic any_wr;
  assign any_wr = wr_lo | wr_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (any_wr) begin
      if (wr_lo) cnt[DW-1:0]  <= wdata;
      if (wr_hi) cnt[CW-1:DW] <= wdata;
    end else if (run) begin
      cnt <= cnt + {{(CW-1){1'b0}}, 1'b1};
    end
  end

  // R2: running counter advances by exactly one
  p_count_r2: assert property (@(posedge clk) disable iff (rst)
    (run && !any_wr) |=> (cnt == $past(cnt) + {{(CW-1){1'b0}}, 1'b1}));

  // R2: stopped counter holds
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!run && !any_wr) |=> $stable(cnt));

  // R3: a half write leaves the other half alone
  p_half_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wr_hi) |=> (cnt[CW-1:DW] == $past(cnt[CW-1:DW])));

endmodule

// File: rtl/gct_compare.sv
module gct_compare #(
  parameter int DW = 32,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic          cen,
  input  logic          ainc,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic          wr_inc,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] cmp,
  output logic [DW-1:0] inc,
  output logic          hit
);

  logic cmp_wr;
  assign cmp_wr = wr_lo | wr_hi;
  assign hit    = cen && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp <= '0;
    end else if (cmp_wr) begin
      if (wr_lo) cmp[DW-1:0]  <= wdata;
      if (wr_hi) cmp[CW-1:DW] <= wdata;
    end else if (hit && ainc) begin
      cmp <= cmp + {{DW{1'b0}}, inc};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      inc <= '0;
    else if (wr_inc)
      inc <= wdata;
  end

  // R7: auto-increment advances the compare value by the increment
  p_autoinc_r7: assert property (@(posedge clk) disable iff (rst)
    (hit && ainc && !cmp_wr) |=> (cmp == $past(cmp) + {{DW{1'b0}}, $past(inc)}));

  // R6/R7: without auto-increment and without a write the compare value is fixed
  p_cmp_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!ainc && !cmp_wr) |=> $stable(cmp));

endmodule

// File: rtl/gct_regs.sv
module gct_regs
  import gct_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADDR_W = 12,
  localparam int CW    = 2 * DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DW-1:0]     wdata,
  input  logic [CW-1:0]     cnt,
  input  logic [CW-1:0]     cmp,
  input  logic [DW-1:0]     inc,
  input  logic              hit,
  output wr_dec_t           dec,
  output logic              run,
  output logic              ainc,
  output logic              cen,
  output logic [DW-1:0]     rdata,
  output logic              irq
);

  logic ist, ien;
  logic [CACK_NUM-1:0] cack;
  logic [GACK_NUM-1:0] gack;

  // Write decode
  always_comb begin
    dec         = '0;
    dec.cnt_lo  = we && (addr == OFF_CNT_LO[ADDR_W-1:0]);
    dec.cnt_hi  = we && (addr == OFF_CNT_HI[ADDR_W-1:0]);
    dec.cnt_ack = we && (addr == OFF_CNT_ACK[ADDR_W-1:0]);
    dec.cmp_lo  = we && (addr == OFF_CMP_LO[ADDR_W-1:0]);
    dec.cmp_hi  = we && (addr == OFF_CMP_HI[ADDR_W-1:0]);
    dec.cmp_inc = we && (addr == OFF_CMP_INC[ADDR_W-1:0]);
    dec.ctrl    = we && (addr == OFF_CTRL[ADDR_W-1:0]);
    dec.ist     = we && (addr == OFF_IST[ADDR_W-1:0]);
    dec.ien     = we && (addr == OFF_IEN[ADDR_W-1:0]);
    dec.gen_ack = we && (addr == OFF_GEN_ACK[ADDR_W-1:0]);
  end

  // Control register
  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      ainc <= 1'b0;
      cen  <= 1'b0;
    end else if (dec.ctrl) begin
      run  <= wdata[CTRL_RUN_BIT];
      ainc <= wdata[CTRL_AINC_BIT];
      cen  <= wdata[CTRL_CEN_BIT];
    end
  end

  // Interrupt enable
  always_ff @(posedge clk) begin
    if (rst)
      ien <= 1'b0;
    else if (dec.ien)
      ien <= wdata[0];
  end

  // Interrupt status: a match wins over a clearing write
  always_ff @(posedge clk) begin
    if (rst)
      ist <= 1'b0;
    else if (hit)
      ist <= 1'b1;
    else if (dec.ist && wdata[0])
      ist <= 1'b0;
  end

  assign irq = ist & ien;

  // Acknowledge registers
  gct_w1c_bits #(.NB(CACK_NUM)) u_cack (
    .clk      (clk),
    .rst      (rst),
    .set_i    ({dec.cnt_hi, dec.cnt_lo}),
    .clr_we   (dec.cnt_ack),
    .clr_mask (wdata[CACK_NUM-1:0]),
    .bits_o   (cack)
  );

  gct_w1c_bits #(.NB(GACK_NUM)) u_gack (
    .clk      (clk),
    .rst      (rst),
    .set_i    ({dec.ctrl, dec.cmp_inc, dec.cmp_hi, dec.cmp_lo}),
    .clr_we   (dec.gen_ack),
    .clr_mask ({wdata[GACK_CTRL_BIT], wdata[GACK_INC_BIT],
                wdata[GACK_CMP_HI_BIT], wdata[GACK_CMP_LO_BIT]}),
    .bits_o   (gack)
  );

  // Registered read mux
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      case (addr)
        OFF_CNT_LO[ADDR_W-1:0]:  rdata <= cnt[DW-1:0];
        OFF_CNT_HI[ADDR_W-1:0]:  rdata <= cnt[CW-1:DW];
        OFF_CNT_ACK[ADDR_W-1:0]: rdata[CACK_NUM-1:0] <= cack;
        OFF_CMP_LO[ADDR_W-1:0]:  rdata <= cmp[DW-1:0];
        OFF_CMP_HI[ADDR_W-1:0]:  rdata <= cmp[CW-1:DW];
        OFF_CMP_INC[ADDR_W-1:0]: rdata <= inc;
        OFF_CTRL[ADDR_W-1:0]: begin
          rdata[CTRL_RUN_BIT]  <= run;
          rdata[CTRL_AINC_BIT] <= ainc;
          rdata[CTRL_CEN_BIT]  <= cen;
        end
        OFF_IST[ADDR_W-1:0]:     rdata[0] <= ist;
        OFF_IEN[ADDR_W-1:0]:     rdata[0] <= ien;
        OFF_GEN_ACK[ADDR_W-1:0]: begin
          rdata[GACK_CMP_LO_BIT] <= gack[0];
          rdata[GACK_CMP_HI_BIT] <= gack[1];
          rdata[GACK_INC_BIT]    <= gack[2];
          rdata[GACK_CTRL_BIT]   <= gack[3];
        end
        default: rdata <= '0;
      endcase
    end
  end

  // R6: a match always leaves the status set
  p_set_r6: assert property (@(posedge clk) disable iff (rst)
    hit |=> ist);

  // R9: a clearing write without a concurrent match drops the status
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (dec.ist && wdata[0] && !hit) |=> !ist);

  // R9: status never falls without a clearing write
  p_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (ist && !(dec.ist && wdata[0])) |=> ist);

  // R10: control write is acknowledged
  p_ctrl_ack_r10: assert property (@(posedge clk) disable iff (rst)
    dec.ctrl |=> gack[3]);

endmodule

// File: rtl/gcount_cmp_timer.sv
module gcount_cmp_timer
  import gct_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq
);

  localparam int CW = 2 * DW;

  wr_dec_t       dec;
  logic          run, ainc, cen, hit;
  logic [CW-1:0] cnt, cmp;
  logic [DW-1:0] inc;

  gct_regs #(.DW(DW), .ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .addr  (bus_addr),
    .we    (bus_we),
    .wdata (bus_wdata),
    .cnt   (cnt),
    .cmp   (cmp),
    .inc   (inc),
    .hit   (hit),
    .dec   (dec),
    .run   (run),
    .ainc  (ainc),
    .cen   (cen),
    .rdata (bus_rdata),
    .irq   (irq)
  );

  gct_counter #(.DW(DW)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .wr_lo (dec.cnt_lo),
    .wr_hi (dec.cnt_hi),
    .wdata (bus_wdata),
    .cnt   (cnt)
  );

  gct_compare #(.DW(DW)) u_cmp (
    .clk    (clk),
    .rst    (rst),
    .cnt    (cnt),
    .cen    (cen),
    .ainc   (ainc),
    .wr_lo  (dec.cmp_lo),
    .wr_hi  (dec.cmp_hi),
    .wr_inc (dec.cmp_inc),
    .wdata  (bus_wdata),
    .cmp    (cmp),
    .inc    (inc),
    .hit    (hit)
  );

  // R8: interrupt only when status is set
  p_irq_src_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(hit) || $past(dec.ien)));

endmodule

// File: tb/gcount_cmp_timer_tb.sv
module gcount_cmp_timer_tb;

  localparam int DW = 32;
  localparam int AW = 12;

  localparam logic [AW-1:0] A_CLO  = 12'h100;
  localparam logic [AW-1:0] A_CHI  = 12'h104;
  localparam logic [AW-1:0] A_CACK = 12'h110;
  localparam logic [AW-1:0] A_MLO  = 12'h200;
  localparam logic [AW-1:0] A_MHI  = 12'h204;
  localparam logic [AW-1:0] A_INC  = 12'h208;
  localparam logic [AW-1:0] A_CTRL = 12'h240;
  localparam logic [AW-1:0] A_IST  = 12'h244;
  localparam logic [AW-1:0] A_IEN  = 12'h248;
  localparam logic [AW-1:0] A_GACK = 12'h24C;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  gcount_cmp_timer #(.DW(DW), .ADDR_W(AW)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk);
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    rd(A_CLO, v);  check("R1 cnt_lo", v, 0);
    rd(A_CHI, v);  check("R1 cnt_hi", v, 0);
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_IST, v);  check("R1 status", v, 0);
    rd(A_GACK, v); check("R1 gen ack", v, 0);
    check("R1 irq", {31'd0, irq}, 0);
    idle(3);
    rd(A_CLO, v);  check("R1 stopped", v, 0);
  endtask

  task automatic t_count_carry;
    logic [DW-1:0] v;
    wr(A_CLO, 32'hFFFF_FFFE);
    wr(A_CHI, 32'h0);
    wr(A_CTRL, 32'h100);
    idle(2);
    wr(A_CTRL, 32'h0);             // three counts
    rd(A_CLO, v); check("R2 carry lo", v, 32'h1);
    rd(A_CHI, v); check("R2 carry hi", v, 32'h1);
    idle(4);
    rd(A_CLO, v); check("R2 hold", v, 32'h1);
  endtask

  task automatic t_live_read;
    logic [DW-1:0] a, b;
    wr(A_CLO, 32'h0);
    wr(A_CHI, 32'h7);
    wr(A_CTRL, 32'h100);
    rd(A_CLO, a);
    rd(A_CLO, b);
    check("R3 live read step", b - a, 32'h1);
    wr(A_CTRL, 32'h0);
    rd(A_CHI, a); check("R3 hi half", a, 32'h7);
  endtask

  task automatic t_cnt_ack;
    logic [DW-1:0] v;
    rd(A_CACK, v); check("R4 both set", v, 32'h3);
    wr(A_CACK, 32'h1);
    rd(A_CACK, v); check("R4 clear bit0", v, 32'h2);
    wr(A_CACK, 32'h2);
    rd(A_CACK, v); check("R4 clear bit1", v, 32'h0);
  endtask

  task automatic t_cmp_regs;
    logic [DW-1:0] v;
    wr(A_GACK, 32'h0001_0007);
    wr(A_MLO, 32'h1234_5678);
    wr(A_MHI, 32'h9ABC_DEF0);
    wr(A_INC, 32'h0000_0055);
    rd(A_MLO, v); check("R5 cmp lo", v, 32'h1234_5678);
    rd(A_MHI, v); check("R5 cmp hi", v, 32'h9ABC_DEF0);
    rd(A_INC, v); check("R5 inc", v, 32'h55);
    rd(A_GACK, v); check("R10 ack cmp/inc", v, 32'h7);
    wr(A_GACK, 32'h0);
    rd(A_GACK, v); check("R10 zero write no effect", v, 32'h7);
    wr(A_GACK, 32'h2);
    rd(A_GACK, v); check("R10 clear bit1", v, 32'h5);
    wr(A_CTRL, 32'h0);
    rd(A_GACK, v); check("R10 ack ctrl", v, 32'h0001_0005);
    wr(A_GACK, 32'h0001_0005);
    rd(A_GACK, v); check("R10 all clear", v, 32'h0);
  endtask

  task automatic t_oneshot;
    logic [DW-1:0] v;
    wr(A_CLO, 0); wr(A_CHI, 0);
    wr(A_MLO, 10); wr(A_MHI, 0); wr(A_INC, 0);
    wr(A_IEN, 1);
    wr(A_CTRL, 32'h101);
    idle(3);
    rd(A_IST, v); check("R6 no early match", v, 0);
    check("R8 irq low before match", {31'd0, irq}, 0);
    idle(15);
    rd(A_IST, v); check("R6 match sets status", v, 1);
    check("R8 irq high", {31'd0, irq}, 1);
    wr(A_CTRL, 0);
    wr(A_IEN, 0);
    check("R8 irq masked", {31'd0, irq}, 0);
    wr(A_IEN, 1);
    check("R8 irq unmasked", {31'd0, irq}, 1);
    wr(A_IST, 1);
    rd(A_IST, v); check("R9 clear", v, 0);
    check("R8 irq after clear", {31'd0, irq}, 0);
    // comparator disabled: no match
    wr(A_CLO, 0); wr(A_MLO, 4);
    wr(A_CTRL, 32'h100);
    idle(10);
    wr(A_CTRL, 0);
    rd(A_IST, v); check("R6 disabled no match", v, 0);
  endtask

  task automatic t_periodic;
    logic [DW-1:0] v;
    wr(A_CLO, 0); wr(A_CHI, 0);
    wr(A_MLO, 5); wr(A_MHI, 0); wr(A_INC, 7);
    wr(A_CTRL, 32'h103);
    idle(14);
    wr(A_CTRL, 0);                 // fifteen counts, matches at 5 and 12
    rd(A_CLO, v); check("R7 final count", v, 15);
    rd(A_MLO, v); check("R7 cmp advanced twice", v, 19);
    rd(A_MHI, v); check("R7 cmp hi", v, 0);
    rd(A_IST, v); check("R7 status set", v, 1);
    wr(A_IST, 1);
  endtask

  task automatic t_collide;
    logic [DW-1:0] v;
    wr(A_CTRL, 0);
    wr(A_CLO, 100); wr(A_CHI, 0);
    wr(A_MLO, 100); wr(A_MHI, 0);
    wr(A_CTRL, 32'h001);           // stopped on the compare value
    idle(2);
    rd(A_IST, v); check("R6 stopped match", v, 1);
    wr(A_IST, 1);
    rd(A_IST, v); check("R9 set beats clear", v, 1);
    wr(A_CTRL, 0);
    wr(A_IST, 0);
    rd(A_IST, v); check("R9 zero write keeps", v, 1);
    wr(A_IST, 1);
    rd(A_IST, v); check("R9 clear after disable", v, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_count_carry();
    t_live_read();
    t_cnt_ack();
    t_cmp_regs();
    t_oneshot();
    t_periodic();
    t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule